// File: doc/BRIEF.md
# 10BASE-T Heartbeat and Link Integrity Control

This block belongs to the 10BASE-T part of an Ethernet transceiver. It has two jobs.

The first job is the heartbeat. After each transmitted frame, when the transmit enable drops, the block waits a set time. It then drives the collision output high for a short, fixed-length pulse. This tells the attached MAC that the collision path works. Three things stop the pulse: a management inhibit bit, full-duplex operation, and repeater operation. The management bit lives in a register outside this block. The block only reads it and never writes it, so automatic suppression never changes the stored bit.

The second job is a three-state link integrity machine with the states fail, waiting-for-idle and passed. It drives the link status output. A silence timer is reloaded by every link pulse and every cycle of valid data. When the timer runs out, the link drops. Two management bits change how the machine behaves. One pins the link in the passed state. The other chooses whether valid data alone brings the link up, or whether valid data must be followed by an idle indication.

The block carries no data stream. Every pin is a plain level-sampled control or status signal, so no valid/ready handshake and no back-pressure apply.

Top module: `sqe_link_ctrl`

## Requirements
- R1: While reset is asserted, and on the first clock after reset is released, `col_out` is 0 and `link_up` is 0.
- R2: A clock edge at which `tx_en` is sampled 0 after being 1 at the previous edge starts the heartbeat. `col_out` rises exactly SQE_DLY clock cycles after that edge and stays high for exactly SQE_LEN cycles.
- R3: While `sqe_inhibit` is 1, no heartbeat pulse is produced. A pulse that is pending or in progress is dropped: `col_out` is 0 in every cycle that follows an edge at which the bit was 1.
- R4: `full_duplex` = 1 or `repeater_mode` = 1 suppresses the heartbeat in the same way as R3, whatever value `sqe_inhibit` has.
- R5: If `tx_en` is sampled 1 again during the delay before the pulse, that pulse is cancelled and `col_out` stays 0.
- R6: While `link_loss_inhibit` is 1, `link_up` is 1 from the cycle after the first edge at which the bit is sampled 1, whatever the receiver inputs are.
- R7: With `squelch_inhibit` = 1, one cycle of `rx_data_valid` = 1 in the fail state sets `link_up` to 1 on the next cycle.
- R8: With `squelch_inhibit` = 0, valid data in the fail state moves the machine to waiting-for-idle, and `link_up` stays 0. A later cycle with `rx_idle` = 1 and `rx_data_valid` = 0 sets `link_up` to 1 on the next cycle.
- R9: The silence timer is reloaded at every edge where `rx_link_pulse` or `rx_data_valid` is 1. If the last such edge is edge a, and `link_loss_inhibit` = 0, `link_up` falls after edge a+LINK_TMO+1. Activity spaced less than LINK_TMO apart keeps the link up.
- R10: Link pulses alone never bring the link up from the fail state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmit enable from the MAC |
| full_duplex | input | 1 | Full-duplex mode flag |
| repeater_mode | input | 1 | Repeater mode flag |
| rx_data_valid | input | 1 | Receiver sees valid 10BASE-T data |
| rx_idle | input | 1 | Receiver sees end-of-frame idle |
| rx_link_pulse | input | 1 | Receiver saw a normal link pulse |
| sqe_inhibit | input | 1 | Management bit: disable heartbeat |
| link_loss_inhibit | input | 1 | Management bit: pin link in passed state |
| squelch_inhibit | input | 1 | Management bit: data alone brings link up |
| col_out | output | 1 | Collision / heartbeat output |
| link_up | output | 1 | Link status (1 = passed) |

## Verification
The bench aims at the exact cycle of the heartbeat. A delay counter that is off by one moves the rising edge or shortens the pulse, and a directed edge count catches either fault. It cancels a pulse by raising transmit enable again during the delay, and it raises each of the three suppression sources in turn. A design that latched the permission only at the falling edge, or ignored one source, would then still pulse. On the link side it checks several things. It checks the exact cycle of the silence timeout. It checks that link pulses alone cannot raise the link. It checks that data without a following idle holds the machine in waiting when squelch inhibit is 0. A design that skipped the idle step, or reloaded the timer on the wrong event, would raise or drop the link one or many cycles off.

// File: rtl/sqe_link_pkg.sv
package sqe_link_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_WAIT  = 2'd1,
    SQ_PULSE = 2'd2
  } sqe_st_t;

  typedef enum logic [1:0] {
    LS_FAIL      = 2'd0,
    LS_WAIT_IDLE = 2'd1,
    LS_PASSED    = 2'd2
  } link_st_t;
endpackage

// File: rtl/sqe_pulse_gen.sv
module sqe_pulse_gen
  import sqe_link_pkg::*;
#(
  parameter int unsigned SQE_DLY = 100,
  parameter int unsigned SQE_LEN = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en,
  input  logic block,
  output logic col_o
);
  localparam int unsigned MAXC = (SQE_DLY > SQE_LEN) ? SQE_DLY : SQE_LEN;
  localparam int unsigned CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] DLY_LAST = CW'(SQE_DLY - 1);
  localparam logic [CW-1:0] LEN_LAST = CW'(SQE_LEN - 1);
  localparam logic [CW-1:0] ONE      = CW'(1);

  sqe_st_t       st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          tx_q;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (block) begin
      st_d  = SQ_IDLE;
      cnt_d = '0;
    end else begin
      case (st_q)
        SQ_IDLE: begin
          if (tx_q && !tx_en) begin
            st_d  = SQ_WAIT;
            cnt_d = '0;
          end
        end
        SQ_WAIT: begin
          if (tx_en) begin
            st_d  = SQ_IDLE;
            cnt_d = '0;
          end else if (cnt_q == DLY_LAST) begin
            st_d  = SQ_PULSE;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + ONE;
          end
        end
        SQ_PULSE: begin
          if (cnt_q == LEN_LAST) begin
            st_d  = SQ_IDLE;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + ONE;
          end
        end
        default: begin
          st_d  = SQ_IDLE;
          cnt_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      cnt_q <= '0;
      tx_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      tx_q  <= tx_en;
    end
  end

  assign col_o = (st_q == SQ_PULSE);

  // R3 R4
  no_sqe_when_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(block) |-> !col_o);

  // R5
  cancel_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_WAIT && tx_en) |=> !col_o);

  // R2
  pulse_after_idle_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(col_o) |-> !$past(tx_en));
endmodule

// File: rtl/link_silence_timer.sv
module link_silence_timer #(
  parameter int unsigned LINK_TMO = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic activity,
  output logic expired
);
  localparam int unsigned TW = $clog2(LINK_TMO + 1);
  localparam logic [TW-1:0] LIMIT = TW'(LINK_TMO);
  localparam logic [TW-1:0] ONE   = TW'(1);

  logic [TW-1:0] sil_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sil_q <= '0;
    end else if (activity) begin
      sil_q <= '0;
    end else if (sil_q != LIMIT) begin
      sil_q <= sil_q + ONE;
    end
  end

  assign expired = (sil_q == LIMIT) && !activity;

  // R9
  timer_saturates_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !activity) |=> (sil_q == LIMIT) || $past(activity));
endmodule

// File: rtl/link_integrity_fsm.sv
module link_integrity_fsm
  import sqe_link_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rx_dv,
  input  logic rx_idle,
  input  logic expired,
  input  logic hold_pass,
  input  logic data_only,
  output logic link_up
);
  link_st_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (hold_pass) begin
      st_d = LS_PASSED;
    end else if (expired) begin
      st_d = LS_FAIL;
    end else begin
      case (st_q)
        LS_FAIL: begin
          if (rx_dv) st_d = data_only ? LS_PASSED : LS_WAIT_IDLE;
        end
        LS_WAIT_IDLE: begin
          if (data_only || (rx_idle && !rx_dv)) st_d = LS_PASSED;
        end
        LS_PASSED: st_d = LS_PASSED;
        default:   st_d = LS_FAIL;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= LS_FAIL;
    else        st_q <= st_d;
  end

  assign link_up = (st_q == LS_PASSED);

  // R6
  hold_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_pass |=> link_up);

  // R8
  needs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == LS_FAIL && rx_dv && !data_only && !hold_pass) |=> (st_q == LS_WAIT_IDLE));

  // R10
  no_up_without_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == LS_FAIL && !rx_dv && !hold_pass) |=> !link_up);

  // R9
  timeout_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !hold_pass) |=> !link_up);
endmodule

// File: rtl/sqe_link_ctrl.sv
module sqe_link_ctrl #(
  parameter int unsigned SQE_DLY  = 100,
  parameter int unsigned SQE_LEN  = 125,
  parameter int unsigned LINK_TMO = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en,
  input  logic full_duplex,
  input  logic repeater_mode,
  input  logic rx_data_valid,
  input  logic rx_idle,
  input  logic rx_link_pulse,
  input  logic sqe_inhibit,
  input  logic link_loss_inhibit,
  input  logic squelch_inhibit,
  output logic col_out,
  output logic link_up
);
  logic sqe_block;
  logic rx_activity;
  logic sil_expired;

  assign sqe_block   = sqe_inhibit | full_duplex | repeater_mode;
  assign rx_activity = rx_link_pulse | rx_data_valid;

  sqe_pulse_gen #(
    .SQE_DLY(SQE_DLY),
    .SQE_LEN(SQE_LEN)
  ) u_sqe (
    .clk   (clk),
    .rst_n (rst_n),
    .tx_en (tx_en),
    .block (sqe_block),
    .col_o (col_out)
  );

  link_silence_timer #(
    .LINK_TMO(LINK_TMO)
  ) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .activity (rx_activity),
    .expired  (sil_expired)
  );

  link_integrity_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_dv     (rx_data_valid),
    .rx_idle   (rx_idle),
    .expired   (sil_expired),
    .hold_pass (link_loss_inhibit),
    .data_only (squelch_inhibit),
    .link_up   (link_up)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !$past(rst_n) |-> (!col_out && !link_up));
endmodule

// File: tb/sqe_link_ctrl_bench.sv
`timescale 1ns/1ps
module sqe_link_ctrl_bench;
  localparam int DLY = 12;
  localparam int LEN = 10;
  localparam int TMO = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 0, full_duplex = 0, repeater_mode = 0;
  logic rx_data_valid = 0, rx_idle = 0, rx_link_pulse = 0;
  logic sqe_inhibit = 0, link_loss_inhibit = 0, squelch_inhibit = 0;
  logic col_out, link_up;

  int checks = 0;
  int failures = 0;
  bit run_cmp = 0;
  bit done = 0;
  string col_tag = "R2";
  string link_tag = "R9";

  always #4 clk = ~clk;

  sqe_link_ctrl #(.SQE_DLY(DLY), .SQE_LEN(LEN), .LINK_TMO(TMO)) u_sqe_link_ctrl (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .full_duplex(full_duplex),
    .repeater_mode(repeater_mode), .rx_data_valid(rx_data_valid), .rx_idle(rx_idle),
    .rx_link_pulse(rx_link_pulse), .sqe_inhibit(sqe_inhibit),
    .link_loss_inhibit(link_loss_inhibit), .squelch_inhibit(squelch_inhibit),
    .col_out(col_out), .link_up(link_up));

  // Reference model built from the requirements
  int m_sqe_ph = 0;   // 0 none, 1 delay, 2 pulse
  int m_sqe_cnt = 0;
  bit m_txq = 0;
  int m_sil = 0;
  int m_lnk = 0;      // 0 fail, 1 waiting for idle, 2 passed

  function automatic bit sqe_blocked(bit inh, bit fd, bit rep);
    return inh | fd | rep;
  endfunction

  function automatic bit sil_out(int sil, bit act);
    return (sil == TMO) && !act;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sqe_ph = 0; m_sqe_cnt = 0; m_txq = 0; m_sil = 0; m_lnk = 0;
    end else begin
      bit act;
      bit exp_t;
      act = rx_link_pulse | rx_data_valid;
      exp_t = sil_out(m_sil, act);
      if (sqe_blocked(sqe_inhibit, full_duplex, repeater_mode)) begin
        m_sqe_ph = 0; m_sqe_cnt = 0;
      end else if (m_sqe_ph == 0) begin
        if (m_txq && !tx_en) begin m_sqe_ph = 1; m_sqe_cnt = 0; end
      end else if (m_sqe_ph == 1) begin
        if (tx_en) begin m_sqe_ph = 0; m_sqe_cnt = 0; end
        else if (m_sqe_cnt == DLY - 1) begin m_sqe_ph = 2; m_sqe_cnt = 0; end
        else m_sqe_cnt++;
      end else begin
        if (m_sqe_cnt == LEN - 1) begin m_sqe_ph = 0; m_sqe_cnt = 0; end
        else m_sqe_cnt++;
      end
      m_txq = tx_en;
      if (link_loss_inhibit) m_lnk = 2;
      else if (exp_t) m_lnk = 0;
      else if (m_lnk == 0 && rx_data_valid) m_lnk = squelch_inhibit ? 2 : 1;
      else if (m_lnk == 1 && (squelch_inhibit || (rx_idle && !rx_data_valid))) m_lnk = 2;
      if (act) m_sil = 0;
      else if (m_sil != TMO) m_sil++;
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_int(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && run_cmp) begin
      chk(col_tag, col_out, (m_sqe_ph == 2));
      chk(link_tag, link_up, (m_lnk == 2));
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Ends a frame and returns the first cycle col_out is seen high and how many cycles it stays high
  task automatic frame_end(output int first, output int highs);
    first = -1; highs = 0;
    tx_en = 1; tick(4);
    tx_en = 0;
    for (int i = 1; i <= DLY + LEN + 6; i++) begin
      @(negedge clk);
      if (col_out) begin
        if (first < 0) first = i;
        highs++;
      end
    end
  endtask

  initial begin
    int first, highs;
    void'($urandom(32'd7349));
    // R1 reset state
    tick(3);
    chk("R1", col_out, 1'b0);
    chk("R1", link_up, 1'b0);
    rst_n = 1; tick(1);
    chk("R1", col_out, 1'b0);
    chk("R1", link_up, 1'b0);
    run_cmp = 1;

    // R2 exact delay and width
    col_tag = "R2";
    frame_end(first, highs);
    chk_int("R2 delay", first, DLY + 1);
    chk_int("R2 width", highs, LEN);

    // R3 management inhibit
    col_tag = "R3"; sqe_inhibit = 1;
    frame_end(first, highs);
    chk_int("R3 pulses", highs, 0);
    sqe_inhibit = 0;
    // R3 inhibit raised mid-pulse drops it
    tx_en = 1; tick(3); tx_en = 0; tick(DLY + 3);
    chk("R3 before", col_out, 1'b1);
    sqe_inhibit = 1; tick(1);
    chk("R3 abort", col_out, 1'b0);
    tick(LEN); sqe_inhibit = 0;

    // R4 full duplex, then repeater, each with inhibit cleared
    col_tag = "R4"; full_duplex = 1;
    frame_end(first, highs);
    chk_int("R4 duplex", highs, 0);
    full_duplex = 0; repeater_mode = 1;
    frame_end(first, highs);
    chk_int("R4 repeater", highs, 0);
    repeater_mode = 0;

    // R5 cancel by tx_en rising during the delay
    col_tag = "R5";
    tx_en = 1; tick(3); tx_en = 0; tick(DLY / 2); tx_en = 1;
    highs = 0;
    for (int i = 0; i < DLY + LEN + 4; i++) begin
      @(negedge clk);
      if (col_out) highs++;
    end
    chk_int("R5 cancelled", highs, 0);
    tx_en = 0; tick(DLY + LEN + 4);

    // R10 and R9: link stays down on pulses only
    link_tag = "R10";
    for (int i = 0; i < 6; i++) begin
      rx_link_pulse = 1; tick(1); rx_link_pulse = 0; tick(40);
    end
    chk("R10 pulses only", link_up, 1'b0);

    // R8 data then idle
    link_tag = "R8";
    rx_data_valid = 1; rx_idle = 0; tick(1);
    rx_data_valid = 0;
    chk("R8 waiting", link_up, 1'b0);
    tick(3);
    chk("R8 still waiting", link_up, 1'b0);
    rx_idle = 1; tick(1); rx_idle = 0;
    chk("R8 up after idle", link_up, 1'b1);

    // R9 periodic pulses keep link, then exact timeout
    link_tag = "R9";
    for (int i = 0; i < 10; i++) begin
      rx_link_pulse = 1; tick(1); rx_link_pulse = 0; tick(TMO / 2);
    end
    chk("R9 kept", link_up, 1'b1);
    rx_link_pulse = 1; tick(1); rx_link_pulse = 0;
    tick(TMO);
    chk("R9 edge before", link_up, 1'b1);
    tick(1);
    chk("R9 dropped", link_up, 1'b0);

    // R7 squelch inhibit: data alone
    link_tag = "R7"; squelch_inhibit = 1;
    rx_data_valid = 1; tick(1); rx_data_valid = 0;
    chk("R7 up", link_up, 1'b1);
    squelch_inhibit = 0;
    tick(TMO + 3);
    chk("R7 timed out", link_up, 1'b0);

    // R6 link loss inhibit pins passed
    link_tag = "R6"; link_loss_inhibit = 1; tick(1);
    chk("R6 up", link_up, 1'b1);
    tick(TMO * 2);
    chk("R6 held", link_up, 1'b1);
    link_loss_inhibit = 0; tick(2);
    chk("R6 released", link_up, 1'b0);

    // Random phase, checked by the model every cycle
    col_tag = "R2"; link_tag = "R9";
    for (int blk = 0; blk < 12; blk++) begin
      sqe_inhibit       = ($urandom % 4) == 0;
      full_duplex       = ($urandom % 6) == 0;
      repeater_mode     = ($urandom % 6) == 0;
      link_loss_inhibit = ($urandom % 8) == 0;
      squelch_inhibit   = ($urandom % 2) == 0;
      for (int c = 0; c < 500; c++) begin
        if (($urandom % 18) == 0) tx_en = ~tx_en;
        rx_data_valid = ($urandom % 30) == 0;
        rx_idle       = ($urandom % 2) == 0;
        rx_link_pulse = ($urandom % 150) == 0;
        tick(1);
      end
    end

    run_cmp = 0;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule